// File: doc/BRIEF.md
# Reset-addressed dual-clock field memory

This block is a serial nibble store used as a programmable delay line. A write port and a read port each run on their own clock. The clocks may differ in rate and have no fixed phase. Each port has an address pointer that only moves forward. A pointer-clear input returns that pointer to address zero on the next rising edge of the port's clock. The block never tracks full or empty. The delay between a nibble entering and the same nibble leaving is set only by when the two pointer clears happen.

Written nibbles do not go straight into the array. They first pass through a small staging queue, which keeps the most recent `STAGE_WORDS` entries. A write-pointer clear drains the queue into the array, one word per write cycle. For this reason the tail of a write pass becomes readable only after the next write clear. The write side also checks two protocol rules. A pass must contain at least `MIN_PASS` enabled writes. Two clears must have at least two low cycles between them. A broken rule raises a one-cycle error pulse.

The array depth is a parameter. The default of 4096 keeps elaboration small. Setting `DEPTH` to 262144 gives a full 512 x 512 field.

Top module: `field_delay_mem`

## Requirements
- R1: While `wr_init` and `rd_init` are held, and after they are released, `rd_data` is 0, both error outputs are 0 and both pointers are at address 0.
- R2: On a write edge with `wr_en`=1 and `wr_clr`=0, `wr_data` is stored at the write pointer and the pointer advances by one.
- R3: On a write edge with `wr_clr`=1, the write pointer becomes 0. On that edge `wr_en` is ignored and nothing is stored.
- R4: On a write edge with `wr_en`=0 and `wr_clr`=0, `wr_data` is discarded and the write pointer keeps its value, however long the enable stays low.
- R5: On a read edge with `rd_en`=1 and `rd_clr`=0, `rd_data` takes the word at the read pointer after that edge and the pointer advances. On a read edge with `rd_clr`=1, the read pointer becomes 0, `rd_en` is ignored and `rd_data` is held.
- R6: On a read edge with `rd_en`=0 and `rd_clr`=0, `rd_data` and the read pointer keep their values.
- R7: A write clear edge pulses `wr_err_spacing` high for one cycle after that edge when fewer than two write edges with `wr_clr`=0 lie between it and the previous clear edge.
- R8: A write clear edge pulses `wr_err_short` high for one cycle after that edge when fewer than `MIN_PASS` enabled writes lie between it and the previous clear edge. The first clear after init never flags.
- R9: The last `STAGE_WORDS` written words do not reach the array until a write clear. Reading their addresses before that clear returns the earlier contents. After the clear they are committed within `STAGE_WORDS`+1 write cycles.
- R10: Both pointers wrap from `DEPTH`-1 to 0. A write pass longer than `DEPTH` overwrites the lowest addresses.
- R11: The k-th enabled read after a read clear returns the k-th enabled write after the matching write clear, with the two clocks at unrelated rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_init | input | 1 | Synchronous active-high init of the write domain |
| wr_clr | input | 1 | Write-pointer clear, sampled on `wr_clk`; also commits staged words |
| wr_en | input | 1 | Write enable |
| wr_data | input | 4 | Nibble to store |
| wr_err_spacing | output | 1 | One-cycle pulse: clears too close together |
| wr_err_short | output | 1 | One-cycle pulse: previous pass shorter than `MIN_PASS` |
| rd_clk | input | 1 | Read-port clock |
| rd_init | input | 1 | Synchronous active-high init of the read domain |
| rd_clr | input | 1 | Read-pointer clear, sampled on `rd_clk` |
| rd_en | input | 1 | Read enable |
| rd_data | output | 4 | Registered nibble read from the array |

## Verification
Each error pulse and each write-pointer change is due in the write cycle right after the sampling edge. A read word is due in the read cycle after an enabled read edge. The bench drives inputs on falling edges and samples 1 ns after the next rising edge, so every check lines up with the register that produces it. A staged word is committed within `STAGE_WORDS`+1 write cycles of a clear. The bench therefore waits 20 idle write cycles, with 8 staged words, before any read that depends on a commit. The uncommitted-read check is taken before that clear, while the staged words cannot yet have reached the array.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/fdm_wr_ctrl.sv
module fdm_wr_ctrl #(
  parameter int DEPTH    = 4096,
  parameter int MIN_PASS = 130,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(MIN_PASS + 1)
) (
  input  logic          clk,
  input  logic          init,
  input  logic          clr,
  input  logic          en,
  output logic [AW-1:0] ptr,
  output logic          err_spacing,
  output logic          err_short
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [1:0]    low_run;   // clr-low edges since last clear, saturating at 2
  logic [CW-1:0] pass_cnt;  // enabled writes since last clear, saturating
  logic          seen_clr;

  always_ff @(posedge clk) begin
    if (init) begin
      ptr         <= '0;
      low_run     <= 2'd2;
      pass_cnt    <= '0;
      seen_clr    <= 1'b0;
      err_spacing <= 1'b0;
      err_short   <= 1'b0;
    end else begin
      err_spacing <= 1'b0;
      err_short   <= 1'b0;
      if (clr) begin
        ptr         <= '0;
        low_run     <= 2'd0;
        pass_cnt    <= '0;
        seen_clr    <= 1'b1;
        err_spacing <= (low_run != 2'd2);
        err_short   <= seen_clr && (pass_cnt < CW'(MIN_PASS));
      end else begin
        if (low_run != 2'd2) low_run <= low_run + 2'd1;
        if (en) begin
          ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
          if (pass_cnt != CW'(MIN_PASS)) pass_cnt <= pass_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fdm_stage.sv
module fdm_stage
  import fdm_pkg::*;
#(
  parameter int DEPTH       = 4096,
  parameter int STAGE_WORDS = 120,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SLOTS = 1 << $clog2(STAGE_WORDS + 1),
  localparam int PW    = $clog2(SLOTS),
  localparam int FW    = PW + 1
) (
  input  logic          clk,
  input  logic          init,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  nib_t          push_data,
  input  logic          commit,
  output logic [FW-1:0] fill,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output nib_t          mem_data
);
  logic [AW-1:0] slot_a [SLOTS];
  nib_t          slot_d [SLOTS];
  logic [PW-1:0] head, tail;
  logic [FW-1:0] flush_left;

  // Retire the oldest entry when more than STAGE_WORDS are held,
  // or while a commit is still draining older entries.
  assign mem_we   = (fill != '0) && ((flush_left != '0) || (fill > FW'(STAGE_WORDS)));
  assign mem_addr = slot_a[head];
  assign mem_data = slot_d[head];

  always_ff @(posedge clk) begin
    if (push) begin
      slot_a[tail] <= push_addr;
      slot_d[tail] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (init) begin
      head       <= '0;
      tail       <= '0;
      fill       <= '0;
      flush_left <= '0;
    end else begin
      if (push)   tail <= tail + 1'b1;
      if (mem_we) head <= head + 1'b1;
      fill <= fill + FW'(push) - FW'(mem_we);
      if (commit)
        flush_left <= fill - FW'(mem_we);
      else if (mem_we && (flush_left != '0))
        flush_left <= flush_left - 1'b1;
    end
  end
endmodule

// File: rtl/fdm_rd_ctrl.sv
module fdm_rd_ctrl #(
  parameter int DEPTH = 4096,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          init,
  input  logic          clr,
  input  logic          en,
  output logic [AW-1:0] ptr,
  output logic          fire
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign fire = en && !clr;

  always_ff @(posedge clk) begin
    if (init || clr)
      ptr <= '0;
    else if (en)
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/fdm_array.sv
module fdm_array
  import fdm_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  nib_t          wd,
  input  logic          rd_clk,
  input  logic          rd_init,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output nib_t          rq
);
  nib_t mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_init)
      rq <= '0;
    else if (re)
      rq <= mem[ra];
  end
endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem
  import fdm_pkg::*;
#(
  parameter int DEPTH       = 4096,
  parameter int STAGE_WORDS = 120,
  parameter int MIN_PASS    = 130
) (
  input  logic             wr_clk,
  input  logic             wr_init,
  input  logic             wr_clr,
  input  logic             wr_en,
  input  logic [NIB_W-1:0] wr_data,
  output logic             wr_err_spacing,
  output logic             wr_err_short,
  input  logic             rd_clk,
  input  logic             rd_init,
  input  logic             rd_clr,
  input  logic             rd_en,
  output logic [NIB_W-1:0] rd_data
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SLOTS = 1 << $clog2(STAGE_WORDS + 1);
  localparam int FW    = $clog2(SLOTS) + 1;

  logic [AW-1:0] wr_ptr, rd_ptr, mem_addr;
  logic [FW-1:0] stage_fill;
  logic          push, mem_we, rd_fire;
  nib_t          mem_data;

  assign push = wr_en && !wr_clr;

  fdm_wr_ctrl #(.DEPTH(DEPTH), .MIN_PASS(MIN_PASS)) u_wr (
    .clk(wr_clk), .init(wr_init), .clr(wr_clr), .en(wr_en),
    .ptr(wr_ptr), .err_spacing(wr_err_spacing), .err_short(wr_err_short)
  );

  fdm_stage #(.DEPTH(DEPTH), .STAGE_WORDS(STAGE_WORDS)) u_stage (
    .clk(wr_clk), .init(wr_init), .push(push), .push_addr(wr_ptr),
    .push_data(wr_data), .commit(wr_clr), .fill(stage_fill),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  fdm_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .init(rd_init), .clr(rd_clr), .en(rd_en),
    .ptr(rd_ptr), .fire(rd_fire)
  );

  fdm_array #(.DEPTH(DEPTH)) u_mem (
    .wr_clk(wr_clk), .we(mem_we), .wa(mem_addr), .wd(mem_data),
    .rd_clk(rd_clk), .rd_init(rd_init), .re(rd_fire), .ra(rd_ptr), .rq(rd_data)
  );
endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
  parameter int DEPTH       = 4096,
  parameter int STAGE_WORDS = 120,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SLOTS = 1 << $clog2(STAGE_WORDS + 1),
  localparam int FW    = $clog2(SLOTS) + 1
) (
  input logic          wr_clk,
  input logic          wr_init,
  input logic          wr_clr,
  input logic          wr_en,
  input logic [AW-1:0] wr_ptr,
  input logic          wr_err_spacing,
  input logic          wr_err_short,
  input logic [FW-1:0] stage_fill,
  input logic          rd_clk,
  input logic          rd_init,
  input logic          rd_clr,
  input logic          rd_en,
  input logic [AW-1:0] rd_ptr,
  input logic [3:0]    rd_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  a_r3_clr_zero: assert property (@(posedge wr_clk) disable iff (wr_init)
    wr_clr |=> (wr_ptr == '0));

  a_r4_hold_ptr: assert property (@(posedge wr_clk) disable iff (wr_init)
    (!wr_clr && !wr_en) |=> $stable(wr_ptr));

  a_r2_advance: assert property (@(posedge wr_clk) disable iff (wr_init)
    (!wr_clr && wr_en) |=> (wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + 1'b1)));

  a_r5_rd_clr: assert property (@(posedge rd_clk) disable iff (rd_init)
    rd_clr |=> ((rd_ptr == '0) && $stable(rd_data)));

  a_r6_rd_hold: assert property (@(posedge rd_clk) disable iff (rd_init)
    (!rd_clr && !rd_en) |=> ($stable(rd_ptr) && $stable(rd_data)));

  a_r7_spacing_at_clr: assert property (@(posedge wr_clk) disable iff (wr_init)
    wr_err_spacing |-> $past(wr_clr));

  a_r8_short_at_clr: assert property (@(posedge wr_clk) disable iff (wr_init)
    wr_err_short |-> $past(wr_clr));

  a_r9_stage_bound: assert property (@(posedge wr_clk) disable iff (wr_init)
    stage_fill <= FW'(STAGE_WORDS + 1));
endmodule

bind field_delay_mem fdm_checker #(.DEPTH(DEPTH), .STAGE_WORDS(STAGE_WORDS)) chk_i (
  .wr_clk(wr_clk), .wr_init(wr_init), .wr_clr(wr_clr), .wr_en(wr_en),
  .wr_ptr(wr_ptr), .wr_err_spacing(wr_err_spacing), .wr_err_short(wr_err_short),
  .stage_fill(stage_fill), .rd_clk(rd_clk), .rd_init(rd_init), .rd_clr(rd_clr),
  .rd_en(rd_en), .rd_ptr(rd_ptr), .rd_data(rd_data)
);

// File: tb/field_delay_mem_tb_top.sv
`timescale 1ns/1ps
module field_delay_mem_tb_top;
  localparam int DEPTH = 256;
  localparam int STAGE = 8;
  localparam int MINP  = 130;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_init = 1'b1, rd_init = 1'b1;
  logic wr_clr = 1'b0, wr_en = 1'b0, rd_clr = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic wr_err_spacing, wr_err_short;
  logic [3:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5  wr_clk = ~wr_clk;   // 200 MHz
  always #3.65 rd_clk = ~rd_clk;   // unrelated read rate

  field_delay_mem #(.DEPTH(DEPTH), .STAGE_WORDS(STAGE), .MIN_PASS(MINP)) dut_i (
    .wr_clk(wr_clk), .wr_init(wr_init), .wr_clr(wr_clr), .wr_en(wr_en),
    .wr_data(wr_data), .wr_err_spacing(wr_err_spacing), .wr_err_short(wr_err_short),
    .rd_clk(rd_clk), .rd_init(rd_init), .rd_clr(rd_clr), .rd_en(rd_en),
    .rd_data(rd_data)
  );

  function automatic logic [3:0] pat(input int sel, input int i);
    case (sel)
      0:       pat = 4'((i * 5 + 1) & 15);
      1:       pat = 4'((i * 3 + 7) & 15);
      default: pat = 4'((i * 11 + 2) & 15);
    endcase
  endfunction

  // mode 0: pass A; 1: pass B with staged tail still old; 2: pass B; 3: wrapped pass C
  function automatic logic [3:0] expv(input int mode, input int i);
    int a;
    a = i % DEPTH;
    case (mode)
      0:       expv = pat(0, i);
      1:       expv = (i < 200 - STAGE) ? pat(1, i) : pat(0, i);
      2:       expv = pat(1, i);
      default: expv = (a < 10) ? pat(2, DEPTH + a) : pat(2, a);
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wstep(input logic c, input logic e, input logic [3:0] d);
    @(negedge wr_clk);
    wr_clr = c; wr_en = e; wr_data = d;
    @(posedge wr_clk);
    #1;
  endtask

  task automatic rstep(input logic c, input logic e);
    @(negedge rd_clk);
    rd_clr = c; rd_en = e;
    @(posedge rd_clk);
    #1;
  endtask

  // Write clear with enable high and data F: enable must be ignored (R3)
  task automatic wclear(input int exp_sp, input int exp_sh, input string tag);
    wstep(1'b1, 1'b1, 4'hF);
    check({tag, " R7 spacing"}, int'(wr_err_spacing), exp_sp);
    check({tag, " R8 short"}, int'(wr_err_short), exp_sh);
  endtask

  task automatic widle(input int n);
    for (int i = 0; i < n; i++) wstep(1'b0, 1'b0, 4'h5);
  endtask

  task automatic wpass(input int sel, input int n, input int gap);
    int k;
    int cyc;
    k = 0; cyc = 0;
    while (k < n) begin
      if (gap > 0 && (cyc % gap) == gap - 1)
        wstep(1'b0, 1'b0, 4'hA);   // discarded (R4)
      else begin
        wstep(1'b0, 1'b1, pat(sel, k));
        k++;
      end
      cyc++;
    end
  endtask

  task automatic rpass(input int mode, input int n, input int gap, input string tag);
    int k;
    int cyc;
    logic [3:0] last;
    last = rd_data;
    rstep(1'b1, 1'b1);
    check({tag, " R5 clear holds output"}, int'(rd_data), int'(last));
    k = 0; cyc = 0;
    while (k < n) begin
      if (gap > 0 && (cyc % gap) == gap - 1) begin
        rstep(1'b0, 1'b0);
        check({tag, " R6 hold"}, int'(rd_data), int'(last));
      end else begin
        rstep(1'b0, 1'b1);
        check({tag, " R11 word"}, int'(rd_data), int'(expv(mode, k)));
        k++;
      end
      last = rd_data;
      cyc++;
    end
    rstep(1'b0, 1'b0);
  endtask

  initial begin
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    #1;
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 spacing", int'(wr_err_spacing), 0);
    check("R1 short", int'(wr_err_short), 0);
    @(negedge wr_clk); wr_init = 1'b0;
    @(negedge rd_clk); rd_init = 1'b0;
    widle(3);
    check("R1 rd_data after init", int'(rd_data), 0);

    // R2 R3 R4: first clear never flags; pass A fills the array exactly
    wclear(0, 0, "first clear");
    wpass(0, DEPTH, 7);
    wclear(0, 0, "after pass A");
    widle(20);
    rpass(0, DEPTH, 5, "R2 pass A");

    // R9: tail of pass B stays staged until the next clear
    wpass(1, 200, 0);
    widle(20);
    rpass(1, 200, 0, "R9 uncommitted");
    wclear(0, 0, "after pass B");
    widle(20);
    rpass(2, 200, 4, "R9 committed");

    // R10: pass longer than the array wraps both pointers
    wpass(2, DEPTH + 10, 6);
    wclear(0, 0, "after pass C");
    widle(20);
    rpass(3, DEPTH + 10, 3, "R10 wrap");

    // R7 R8 protocol checks
    wpass(0, MINP - 1, 0);
    wclear(0, 1, "R8 one short");
    widle(1);
    wclear(1, 1, "R7 one low cycle");
    wpass(0, MINP, 0);
    wclear(0, 0, "R8 exact minimum");
    widle(2);
    wclear(0, 1, "R7 two low cycles");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule